// File: doc/BRIEF.md
# Trapping Integer ALU

This block is the add, subtract and bitwise part of a 32-bit integer execution path. A single operation code picks one of twelve register operations: add and subtract that consume the carry and raise an overflow trap, unsigned add and subtract that produce a carry, plain add and subtract that ignore the carry entirely, tagged add and subtract for dynamically typed runtimes, AND, OR, XOR, and a bounds check for array indexing and subrange narrowing.

The result and the three trap flags are combinational in the operands, the operation code and the current carry flag. The carry flag is the only state. It is written at the rising clock edge when the update enable is high, the operation changes the carry, and no trap is raised by that operation. A trapping operation still drives its result, so a trap handler can inspect the value that would have been written.

Top module: `trap_alu`

## Requirements
- R1: After reset the carry flag output is 0.
- R2: Code 0 gives Ra+Rb+carry and code 1 gives Ra-Rb-carry; both clear the carry and raise the overflow trap when the true signed result does not fit in 32 bits.
- R3: Code 2 gives Ra+Rb+carry and loads the carry with the carry-out of the 32-bit add; code 3 gives Ra-Rb-carry and loads the carry with the borrow (1 when Ra < Rb+carry unsigned); neither ever traps.
- R4: Code 4 gives Ra+Rb and code 5 gives Ra-Rb, with no carry in, no trap and no change to the carry.
- R5: Code 6 gives Ra+Rb and code 7 gives Ra-Rb with no carry in and clear the carry; they raise the overflow trap on signed overflow and the tag trap when bit 31 differs from bit 30 in Ra, in Rb or in the result.
- R6: Code 11 passes Ra to the result, leaves the carry unchanged, and raises the bounds trap when Ra is negative or when the exact signed difference Ra-Rb is zero or positive (no wrap-around).
- R7: Codes 8, 9 and 10 give Ra AND Rb, Ra OR Rb and Ra XOR Rb, never trap and leave the carry unchanged.
- R8: Whenever any trap flag is high, the carry keeps its value across the next clock edge, and the result is still the computed value.
- R9: With the carry update enable low, the carry keeps its value whatever the operation.
- R10: Codes 12 to 15 give a zero result, raise no trap and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 4 | Operation code |
| ra | input | 32 | First operand |
| rb | input | 32 | Second operand |
| carryEn | input | 1 | Allows the carry flag to be written at the clock edge |
| result | output | 32 | Operation result |
| ovfTrap | output | 1 | Signed overflow trap |
| tagTrap | output | 1 | Tag mismatch trap of the tagged operations |
| bndTrap | output | 1 | Bounds check trap |
| carryFlag | output | 1 | Current carry flag |

## Verification
The result and all three trap flags are due in the same cycle as the operands, while the carry written by an operation is due only after the following rising edge. The bench therefore drives each operation at a falling edge, compares result and traps one nanosecond later against a behavioural model using wide signed integers, and compares the carry flag at the next falling edge, after the model has applied its own update rule at the rising edge. Directed corner values (sign boundaries, all-ones, tag boundaries, bounds edges) are followed by a long mixed sequence compared every clock.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

  localparam logic [3:0] OP_ADD_CHK = 4'd0;
  localparam logic [3:0] OP_SUB_CHK = 4'd1;
  localparam logic [3:0] OP_ADD_UNS = 4'd2;
  localparam logic [3:0] OP_SUB_UNS = 4'd3;
  localparam logic [3:0] OP_ADD_PLN = 4'd4;
  localparam logic [3:0] OP_SUB_PLN = 4'd5;
  localparam logic [3:0] OP_ADD_TAG = 4'd6;
  localparam logic [3:0] OP_SUB_TAG = 4'd7;
  localparam logic [3:0] OP_AND     = 4'd8;
  localparam logic [3:0] OP_OR      = 4'd9;
  localparam logic [3:0] OP_XOR     = 4'd10;
  localparam logic [3:0] OP_BOUND   = 4'd11;

  typedef enum logic [1:0] {
    CY_KEEP,
    CY_CLEAR,
    CY_LOAD,
    CY_LOAD_INV
  } carryModeE;

  typedef enum logic [2:0] {
    RS_ADDER,
    RS_AND,
    RS_OR,
    RS_XOR,
    RS_PASS_A,
    RS_ZERO
  } resSelE;

  typedef struct packed {
    logic      subtract;
    logic      useCarry;
    logic      ovfCheck;
    logic      tagCheck;
    logic      bndCheck;
    carryModeE carryMode;
    resSelE    resSel;
  } aluStrobesT;

endpackage

// File: rtl/trap_alu_ctrl.sv
module trap_alu_ctrl
  import trap_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobesT strobes
);

  always_comb begin
    strobes = '{subtract: 1'b0, useCarry: 1'b0, ovfCheck: 1'b0,
                tagCheck: 1'b0, bndCheck: 1'b0,
                carryMode: CY_KEEP, resSel: RS_ZERO};
    case (opSel)
      OP_ADD_CHK: begin
        strobes.useCarry  = 1'b1;
        strobes.ovfCheck  = 1'b1;
        strobes.carryMode = CY_CLEAR;
        strobes.resSel    = RS_ADDER;
      end
      OP_SUB_CHK: begin
        strobes.subtract  = 1'b1;
        strobes.useCarry  = 1'b1;
        strobes.ovfCheck  = 1'b1;
        strobes.carryMode = CY_CLEAR;
        strobes.resSel    = RS_ADDER;
      end
      OP_ADD_UNS: begin
        strobes.useCarry  = 1'b1;
        strobes.carryMode = CY_LOAD;
        strobes.resSel    = RS_ADDER;
      end
      OP_SUB_UNS: begin
        strobes.subtract  = 1'b1;
        strobes.useCarry  = 1'b1;
        strobes.carryMode = CY_LOAD_INV;
        strobes.resSel    = RS_ADDER;
      end
      OP_ADD_PLN: strobes.resSel = RS_ADDER;
      OP_SUB_PLN: begin
        strobes.subtract = 1'b1;
        strobes.resSel   = RS_ADDER;
      end
      OP_ADD_TAG: begin
        strobes.ovfCheck  = 1'b1;
        strobes.tagCheck  = 1'b1;
        strobes.carryMode = CY_CLEAR;
        strobes.resSel    = RS_ADDER;
      end
      OP_SUB_TAG: begin
        strobes.subtract  = 1'b1;
        strobes.ovfCheck  = 1'b1;
        strobes.tagCheck  = 1'b1;
        strobes.carryMode = CY_CLEAR;
        strobes.resSel    = RS_ADDER;
      end
      OP_AND:   strobes.resSel = RS_AND;
      OP_OR:    strobes.resSel = RS_OR;
      OP_XOR:   strobes.resSel = RS_XOR;
      OP_BOUND: begin
        strobes.bndCheck = 1'b1;
        strobes.resSel   = RS_PASS_A;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/trap_alu_datapath.sv
module trap_alu_datapath
  import trap_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobesT       strobes,
  input  logic [WIDTH-1:0] ra,
  input  logic [WIDTH-1:0] rb,
  input  logic             carryEn,
  output logic [WIDTH-1:0] result,
  output logic             ovfTrap,
  output logic             tagTrap,
  output logic             bndTrap,
  output logic             carryQ
);

  localparam int MSB = WIDTH - 1;
  localparam int TAG = WIDTH - 2;

  logic [WIDTH-1:0] bEff;
  logic             cinEff;
  logic [WIDTH:0]   sum;
  logic             ovfRaw;
  logic             tagBad;
  logic             bndHit;
  logic             anyTrap;

  // Subtraction is a + ~b + 1 - carry, so the carry-in inverts.
  assign bEff   = strobes.subtract ? ~rb : rb;
  assign cinEff = (strobes.useCarry & carryQ) ^ strobes.subtract;
  assign sum    = {1'b0, ra} + {1'b0, bEff} + {{WIDTH{1'b0}}, cinEff};

  assign ovfRaw = (ra[MSB] == bEff[MSB]) && (sum[MSB] != ra[MSB]);
  assign tagBad = (ra[MSB] ^ ra[TAG]) | (rb[MSB] ^ rb[TAG]) |
                  (sum[MSB] ^ sum[TAG]);
  // Exact comparison on sign-extended operands: Ra-Rb >= 0 never wraps.
  assign bndHit = ra[MSB] |
                  ($signed({ra[MSB], ra}) >= $signed({rb[MSB], rb}));

  assign ovfTrap = strobes.ovfCheck & ovfRaw;
  assign tagTrap = strobes.tagCheck & tagBad;
  assign bndTrap = strobes.bndCheck & bndHit;
  assign anyTrap = ovfTrap | tagTrap | bndTrap;

  always_comb begin
    case (strobes.resSel)
      RS_ADDER:  result = sum[WIDTH-1:0];
      RS_AND:    result = ra & rb;
      RS_OR:     result = ra | rb;
      RS_XOR:    result = ra ^ rb;
      RS_PASS_A: result = ra;
      default:   result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
    end else if (carryEn && !anyTrap) begin
      case (strobes.carryMode)
        CY_CLEAR:    carryQ <= 1'b0;
        CY_LOAD:     carryQ <= sum[WIDTH];
        CY_LOAD_INV: carryQ <= ~sum[WIDTH];
        default:     carryQ <= carryQ;
      endcase
    end
  end

  // R8
  trap_carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap || tagTrap || bndTrap) |=> $stable(carryQ));

  // R9
  no_enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !carryEn |=> $stable(carryQ));

endmodule

// File: rtl/trap_alu.sv
module trap_alu
  import trap_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] ra,
  input  logic [WIDTH-1:0] rb,
  input  logic             carryEn,
  output logic [WIDTH-1:0] result,
  output logic             ovfTrap,
  output logic             tagTrap,
  output logic             bndTrap,
  output logic             carryFlag
);

  aluStrobesT strobes;

  trap_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  trap_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ra      (ra),
    .rb      (rb),
    .carryEn (carryEn),
    .result  (result),
    .ovfTrap (ovfTrap),
    .tagTrap (tagTrap),
    .bndTrap (bndTrap),
    .carryQ  (carryFlag)
  );

  // R4
  plain_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_ADD_PLN || opSel == OP_SUB_PLN) |->
      !(ovfTrap || tagTrap || bndTrap));

  // R6
  bound_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_BOUND) |-> (result == ra && !ovfTrap && !tagTrap));

  // R7
  logic_carry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR) |=>
      $stable(carryFlag));

  // R5
  tagged_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opSel == OP_ADD_TAG || opSel == OP_SUB_TAG) && carryEn &&
     !ovfTrap && !tagTrap) |=> !carryFlag);

  // R3
  unsigned_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_ADD_UNS || opSel == OP_SUB_UNS) |->
      !(ovfTrap || tagTrap || bndTrap));

endmodule

// File: tb/trap_alu_bench.sv
module trap_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = 4'd0;
  logic [31:0] ra = '0;
  logic [31:0] rb = '0;
  logic        carryEn = 1'b0;
  logic [31:0] result;
  logic        ovfTrap, tagTrap, bndTrap, carryFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mCarry = 1'b0;

  always #4 clk = ~clk;

  trap_alu u_trap_alu (
    .clk(clk), .rstN(rstN), .opSel(opSel), .ra(ra), .rb(rb),
    .carryEn(carryEn), .result(result), .ovfTrap(ovfTrap),
    .tagTrap(tagTrap), .bndTrap(bndTrap), .carryFlag(carryFlag)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8, 4'd9, 4'd10: return "R7";
      4'd11: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic bit tagOk(input logic [31:0] v);
    return v[31] == v[30];
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic en);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint c  = mCarry ? 64'sd1 : 64'sd0;
    longint t  = 0;
    logic [31:0] eRes = '0;
    bit eOvf = 0, eTag = 0, eBnd = 0;
    bit nextC = mCarry;
    string carryReq;
    case (op)
      4'd0: begin t = sa + sb + c; nextC = 0; eOvf = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd1: begin t = sa - sb - c; nextC = 0; eOvf = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd2: begin t = ua + ub + c; nextC = (t >= 64'sd4294967296); end
      4'd3: begin t = ua - ub - c; nextC = (t < 0); end
      4'd4: t = sa + sb;
      4'd5: t = sa - sb;
      4'd6, 4'd7: begin
        t = (op == 4'd6) ? sa + sb : sa - sb;
        nextC = 0;
        eOvf = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'd8:  t = longint'({32'd0, a & b});
      4'd9:  t = longint'({32'd0, a | b});
      4'd10: t = longint'({32'd0, a ^ b});
      4'd11: begin t = ua; eBnd = (sa < 0) || (sa - sb >= 0); end
      default: t = 0;
    endcase
    eRes = t[31:0];
    if (op == 4'd6 || op == 4'd7)
      eTag = !tagOk(a) || !tagOk(b) || !tagOk(eRes);
    opSel = op; ra = a; rb = b; carryEn = en;
    #1;
    checks++;
    if (result !== eRes) begin
      errors++;
      $display("FAIL %s result op=%0d actual=%h expected=%h", reqOf(op), op, result, eRes);
    end
    checks++;
    if ({ovfTrap, tagTrap, bndTrap} !== {eOvf, eTag, eBnd}) begin
      errors++;
      $display("FAIL %s traps op=%0d actual=%b expected=%b", reqOf(op), op,
               {ovfTrap, tagTrap, bndTrap}, {eOvf, eTag, eBnd});
    end
    if (eOvf || eTag || eBnd) carryReq = "R8";
    else if (!en) carryReq = "R9";
    else carryReq = reqOf(op);
    @(posedge clk);
    if (en && !(eOvf || eTag || eBnd)) mCarry = nextC;
    @(negedge clk);
    checks++;
    if (carryFlag !== mCarry) begin
      errors++;
      $display("FAIL %s carry op=%0d actual=%b expected=%b", carryReq, op, carryFlag, mCarry);
    end
  endtask

  function automatic logic [31:0] pickVal(input int sel);
    case (sel % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h3FFF_FFFF;
      4: return 32'hC000_0000;
      5: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (carryFlag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset carry actual=%b expected=0", carryFlag);
    end
    @(negedge clk);
    // R3: carry out of all-ones plus one
    runOp(4'd2, 32'hFFFF_FFFF, 32'd1, 1'b1);
    // R9: enable low keeps carry across an op that would clear it
    runOp(4'd0, 32'd0, 32'd0, 1'b0);
    // R2: carry consumed then cleared
    runOp(4'd0, 32'd0, 32'd0, 1'b1);
    // R3: borrow sets carry
    runOp(4'd3, 32'd0, 32'd1, 1'b1);
    // R2: subtract with borrow in
    runOp(4'd1, 32'd5, 32'd3, 1'b1);
    // R3 then R8: overflow trap keeps the set carry
    runOp(4'd2, 32'hFFFF_FFFF, 32'd1, 1'b1);
    runOp(4'd0, 32'h7FFF_FFFF, 32'd0, 1'b1);
    runOp(4'd1, 32'h8000_0000, 32'd0, 1'b1);
    // R4: plain ops ignore carry and never trap
    runOp(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1);
    runOp(4'd5, 32'h8000_0000, 32'd1, 1'b1);
    // R5: tag mismatch in operand, in result, and clean case
    runOp(4'd6, 32'h4000_0000, 32'd0, 1'b1);
    runOp(4'd6, 32'h3FFF_FFFF, 32'd1, 1'b1);
    runOp(4'd7, 32'd10, 32'd3, 1'b1);
    // R6: bounds edges
    runOp(4'd11, 32'hFFFF_FFFF, 32'd100, 1'b1);
    runOp(4'd11, 32'd5, 32'h8000_0000, 1'b1);
    runOp(4'd11, 32'd3, 32'd10, 1'b1);
    runOp(4'd11, 32'd10, 32'd10, 1'b1);
    runOp(4'd11, 32'd9, 32'd10, 1'b1);
    // R7 and R10
    runOp(4'd8, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1);
    runOp(4'd9, 32'hF0F0_1234, 32'h0FF0_0000, 1'b1);
    runOp(4'd10, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1);
    for (int k = 12; k < 16; k++) runOp(4'(k), 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    // mixed sequence compared every clock
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op = 4'($urandom % 16);
      logic [31:0] a = pickVal(int'($urandom % 16));
      logic [31:0] b = pickVal(int'($urandom % 16));
      runOp(op, a, b, ($urandom % 5) != 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule